// File: doc/BRIEF.md
# Ethernet Pause Frame Transmit Sequencer

This block sits beside the transmit data path of a full-duplex Ethernet MAC and sends a flow-control PAUSE frame when software asks for one. A one-cycle request pulse arms a pending request. The block then asks the data path to stop gracefully, and it waits until the data path reports that it is idle. At that point it raises a one-cycle stop-complete interrupt and streams the control frame as bytes over a valid/ready interface.

The frame is 60 bytes long and does not include preamble or CRC. It carries the reserved pause multicast destination, the station's own address as the source, the MAC-control type, the pause opcode and the programmed 16-bit quanta count. Zero padding fills the rest of the frame. When the last byte is accepted, the pending request and the graceful-stop request both drop. Normal traffic can then resume.

A request made while full-duplex operation is disabled is discarded and nothing is sent.

Top module: `pause_tx_seq`

## Requirements
- R1: After reset, out_valid, out_sop, out_eop, stop_req, req_busy and stop_done_irq are all low.
- R2: A req_set pulse seen in the idle state with fd_en high makes req_busy and stop_req high from the next cycle on.
- R3: A req_set pulse seen while fd_en is low is discarded: req_busy, stop_req and out_valid stay low.
- R4: While the data path is not idle (dp_idle low), stop_req stays high and no byte is offered (out_valid low).
- R5: When dp_idle is sampled high while stopping, stop_done_irq is high for exactly one cycle, starting in the next cycle. That is the same cycle in which the first frame byte is offered with out_sop high.
- R6: The frame is 60 bytes in this order:
  - bytes 0–5 are 01 80 C2 00 00 01;
  - bytes 6–11 are src_mac, most significant byte first;
  - bytes 12–13 are 88 08;
  - bytes 14–15 are 00 01;
  - bytes 16–17 are pause_dur, high byte first;
  - bytes 18–59 are 00.
- R7: out_sop is high only with byte 0 and out_eop is high only with byte 59.
- R8: While out_valid is high and out_ready is low, out_data, out_sop and out_eop hold their values.
- R9: In the cycle after byte 59 is accepted, req_busy, stop_req and out_valid are low.
- R10: src_mac and pause_dur are captured when streaming starts. Later changes to them do not alter the frame in flight.
- R11: A req_set pulse while req_busy is high has no effect. Exactly one frame is sent, and the block is idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_set | input | 1 | One-cycle software request to send a pause frame |
| fd_en | input | 1 | Full-duplex mode enable |
| src_mac | input | 48 | Station MAC address |
| pause_dur | input | 16 | Programmed pause quanta |
| dp_idle | input | 1 | Normal data path has finished its current frame |
| out_ready | input | 1 | Downstream accepts the offered byte |
| out_valid | output | 1 | Byte offered |
| out_data | output | 8 | Frame byte |
| out_sop | output | 1 | First byte of frame |
| out_eop | output | 1 | Last byte of frame |
| stop_req | output | 1 | Graceful-stop request to the data path |
| req_busy | output | 1 | Pause request pending |
| stop_done_irq | output | 1 | One-cycle stop-complete interrupt |

## Verification
The hardest situation to create is a change to the duration and address inputs, or a second request, arriving in the middle of a frame while backpressure stalls the stream. Only then is it visible whether the fields were captured and whether the in-flight frame stays intact. Random trials combine three things: a random wait before the data path goes idle, random per-cycle ready with several acceptance rates, and re-programming of src_mac and pause_dur after the first byte. Some trials also pulse req_set in the middle of the frame. Directed cases cover a zero and an all-ones duration, a request with full-duplex off, and back-to-back acceptance with no stall.

// File: rtl/pause_tx_pkg.sv
package pause_tx_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_STOP = 2'd1,
        SQ_SEND = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pause_tx_ctrl.sv
module pause_tx_ctrl
    import pause_tx_pkg::*;
#(
    parameter int FRAME_LEN = 60,
    localparam int IDX_W = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_set,
    input  logic             fd_en,
    input  logic             dp_idle,
    input  logic             out_ready,
    output logic [IDX_W-1:0] idx,
    output logic             capture,
    output logic             sending,
    output logic             pending,
    output logic             irq
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic             irq;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.irq = 1'b0;
        capture   = 1'b0;
        case (ctl_q.st)
            SQ_IDLE: begin
                // requests with full duplex off are dropped here
                if (req_set && fd_en) begin
                    ctl_d.st = SQ_STOP;
                end
            end
            SQ_STOP: begin
                if (dp_idle) begin
                    ctl_d.st  = SQ_SEND;
                    ctl_d.idx = '0;
                    ctl_d.irq = 1'b1;
                    capture   = 1'b1;
                end
            end
            SQ_SEND: begin
                if (out_ready) begin
                    if (ctl_q.idx == LAST) begin
                        ctl_d.st  = SQ_IDLE;
                        ctl_d.idx = '0;
                    end else begin
                        ctl_d.idx = ctl_q.idx + 1'b1;
                    end
                end
            end
            default: ctl_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: SQ_IDLE, idx: '0, irq: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign idx     = ctl_q.idx;
    assign sending = (ctl_q.st == SQ_SEND);
    assign pending = (ctl_q.st != SQ_IDLE);
    assign irq     = ctl_q.irq;
endmodule

// File: rtl/pause_field_reg.sv
module pause_field_reg #(
    parameter int ADDR_W = 48,
    parameter int DUR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [DUR_W-1:0]  dur_in,
    output logic [ADDR_W-1:0] src_out,
    output logic [DUR_W-1:0]  dur_out
);
    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [DUR_W-1:0]  dur;
    } fld_t;

    fld_t fld_d, fld_q;

    always_comb begin
        fld_d = fld_q;
        if (capture) begin
            fld_d.src = src_in;
            fld_d.dur = dur_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else begin
            fld_q <= fld_d;
        end
    end

    assign src_out = fld_q.src;
    assign dur_out = fld_q.dur;
endmodule

// File: rtl/pause_byte_gen.sv
module pause_byte_gen #(
    parameter int          FRAME_LEN = 60,
    parameter logic [47:0] DEST_ADDR = 48'h0180_C200_0001,
    parameter logic [15:0] CTRL_TYPE = 16'h8808,
    parameter logic [15:0] CTRL_OP   = 16'h0001,
    localparam int IDX_W = $clog2(FRAME_LEN)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [47:0]      src,
    input  logic [15:0]      dur,
    output logic [7:0]       data
);
    localparam int SRC_OFF = 6;
    localparam int HDR_OFF = 12;
    localparam int PAD_OFF = 18;

    logic [47:0]      hdr;
    logic [IDX_W+2:0] sh_da, sh_sa, sh_hd;
    logic [47:0]      da_s, sa_s, hd_s;

    assign hdr   = {CTRL_TYPE, CTRL_OP, dur};
    assign sh_da = {idx, 3'b000};
    assign sh_sa = {idx - IDX_W'(SRC_OFF), 3'b000};
    assign sh_hd = {idx - IDX_W'(HDR_OFF), 3'b000};
    assign da_s  = DEST_ADDR << sh_da;
    assign sa_s  = src << sh_sa;
    assign hd_s  = hdr << sh_hd;

    always_comb begin
        if (idx < IDX_W'(SRC_OFF)) begin
            data = da_s[47:40];
        end else if (idx < IDX_W'(HDR_OFF)) begin
            data = sa_s[47:40];
        end else if (idx < IDX_W'(PAD_OFF)) begin
            data = hd_s[47:40];
        end else begin
            data = 8'h00;
        end
    end
endmodule

// File: rtl/pause_tx_seq.sv
module pause_tx_seq #(
    parameter int FRAME_LEN = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_set,
    input  logic        fd_en,
    input  logic [47:0] src_mac,
    input  logic [15:0] pause_dur,
    input  logic        dp_idle,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_sop,
    output logic        out_eop,
    output logic        stop_req,
    output logic        req_busy,
    output logic        stop_done_irq
);
    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

    logic [IDX_W-1:0] idx;
    logic             capture, sending, pending;
    logic [47:0]      src_q;
    logic [15:0]      dur_q;

    pause_tx_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .fd_en(fd_en),
        .dp_idle(dp_idle), .out_ready(out_ready), .idx(idx),
        .capture(capture), .sending(sending), .pending(pending),
        .irq(stop_done_irq)
    );

    pause_field_reg #(.ADDR_W(48), .DUR_W(16)) u_fields (
        .clk(clk), .rst_n(rst_n), .capture(capture),
        .src_in(src_mac), .dur_in(pause_dur),
        .src_out(src_q), .dur_out(dur_q)
    );

    pause_byte_gen #(.FRAME_LEN(FRAME_LEN)) u_bytes (
        .idx(idx), .src(src_q), .dur(dur_q), .data(out_data)
    );

    assign out_valid = sending;
    assign out_sop   = sending && (idx == '0);
    assign out_eop   = sending && (idx == LAST);
    assign stop_req  = pending;
    assign req_busy  = pending;
endmodule

// File: rtl/pause_tx_seq_chk.sv
module pause_tx_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_set,
    input logic        fd_en,
    input logic        dp_idle,
    input logic        out_ready,
    input logic        out_valid,
    input logic [7:0]  out_data,
    input logic        out_sop,
    input logic        out_eop,
    input logic        stop_req,
    input logic        req_busy,
    input logic        stop_done_irq
);
    AST_START_NEEDS_FD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_req) |-> $past(fd_en) && $past(req_set)); // R3
    AST_NO_SEND_BUSY_DP: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !out_valid && !dp_idle) |=> !out_valid && stop_req); // R4
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done_irq |=> !stop_done_irq); // R5
    AST_IRQ_WITH_SOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done_irq |-> out_valid && out_sop); // R5
    AST_MARK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_valid && !(out_sop && out_eop)); // R7
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data)
            && $stable(out_sop) && $stable(out_eop)); // R8
    AST_CLEAR_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> !req_busy && !stop_req && !out_valid); // R9
    AST_VALID_UNDER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> stop_req && req_busy); // R2
endmodule

bind pause_tx_seq pause_tx_seq_chk i_chk (.*);

// File: tb/test_pause_tx_seq.sv
module test_pause_tx_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_set = 1'b0, fd_en = 1'b1, dp_idle = 1'b0, out_ready = 1'b0;
    logic [47:0] src_mac = '0;
    logic [15:0] pause_dur = '0;
    logic        out_valid, out_sop, out_eop, stop_req, req_busy, stop_done_irq;
    logic [7:0]  out_data;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pause_tx_seq i_pause_tx_seq (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i, input logic [47:0] sa,
                                            input logic [15:0] d);
        logic [47:0] da = 48'h0180_C200_0001;
        if (i < 6)  return da[8*(5-i) +: 8];
        if (i < 12) return sa[8*(11-i) +: 8];
        if (i == 12) return 8'h88;
        if (i == 13) return 8'h08;
        if (i == 14) return 8'h00;
        if (i == 15) return 8'h01;
        if (i == 16) return d[15:8];
        if (i == 17) return d[7:0];
        return 8'h00;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_idle(input string req, input int n);
        for (int k = 0; k < n; k++) begin
            chk(!req_busy && !stop_req && !out_valid && !stop_done_irq, req, "idle outputs",
                {req_busy, stop_req, out_valid, stop_done_irq}, 4'h0);
            tick();
        end
    endtask

    task automatic run_frame(input logic [47:0] sa, input logic [15:0] d,
                             input int idle_wait, input int rdy_pct, input bit poke);
        int n = 0;
        int guard = 0;
        bit have_prev = 0;
        bit poked = 0;
        logic [7:0] prev = '0;
        src_mac = sa; pause_dur = d; dp_idle = 1'b0; out_ready = 1'b0;
        req_set = 1'b1;
        tick();
        req_set = 1'b0;
        chk(req_busy && stop_req, "R2", "busy/stop after request", {req_busy, stop_req}, 2'b11);
        for (int k = 0; k < idle_wait; k++) begin
            chk(stop_req && !out_valid, "R4", "no byte before idle", {stop_req, out_valid}, 2'b10);
            tick();
        end
        dp_idle = 1'b1;
        tick();
        dp_idle = 1'b0;
        chk(stop_done_irq && out_valid && out_sop, "R5", "irq with first byte",
            {stop_done_irq, out_valid, out_sop}, 3'b111);
        while (n < 60 && guard < 5000) begin
            guard++;
            if (guard > 1) begin
                chk(!stop_done_irq, "R5", "irq single cycle", stop_done_irq, 0);
                if (poke) begin
                    src_mac = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
                    pause_dur = 16'($urandom);
                end
            end
            req_set = (poke && n == 30 && !poked);
            if (req_set) poked = 1;
            chk(out_valid, "R6", "valid during frame", out_valid, 1);
            chk(out_data == exp_byte(n, sa, d), "R10", $sformatf("byte %0d", n),
                out_data, exp_byte(n, sa, d));
            chk(out_sop == (n == 0) && out_eop == (n == 59), "R7", $sformatf("markers %0d", n),
                {out_sop, out_eop}, {n == 0, n == 59});
            if (have_prev) chk(out_data == prev, "R8", "hold on stall", out_data, prev);
            out_ready = ($urandom % 100) < rdy_pct;
            have_prev = !out_ready;
            prev = out_data;
            if (out_ready) n++;
            tick();
        end
        req_set = 1'b0;
        out_ready = 1'b0;
        chk(n == 60, "R6", "bytes accepted", n, 60);
        chk(!req_busy && !stop_req && !out_valid, "R9", "cleared after last",
            {req_busy, stop_req, out_valid}, 3'b000);
        check_idle("R11", 3);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        #5;
        chk(!out_valid && !out_sop && !out_eop && !stop_req && !req_busy && !stop_done_irq,
            "R1", "in reset", {out_valid, stop_req, req_busy, stop_done_irq}, 0);
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk(!out_valid && !stop_req && !req_busy && !stop_done_irq, "R1", "after reset",
            {out_valid, stop_req, req_busy, stop_done_irq}, 0);
        // R3: request with full duplex off
        fd_en = 1'b0; dp_idle = 1'b1; req_set = 1'b1;
        tick();
        req_set = 1'b0;
        check_idle("R3", 6);
        fd_en = 1'b1; dp_idle = 1'b0;
        // directed corner cases
        run_frame(48'h0011_2233_4455, 16'h0000, 0, 100, 0);
        run_frame(48'hFFFF_FFFF_FFFF, 16'hFFFF, 3, 100, 0);
        run_frame(48'hA5A5_5A5A_0F0F, 16'h1234, 5, 30, 1);
        // random trials
        for (int t = 0; t < 24; t++) begin
            run_frame({$urandom, $urandom} & 48'hFFFF_FFFF_FFFF, 16'($urandom),
                      int'($urandom % 8), 20 + int'($urandom % 81), t[0]);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule